// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Controller

This block sits on the memory side of a shared word-addressed store. It makes load-linked / store-conditional pairs atomic without knowing which client issued them. A load-linked command reads a word and opens a reservation on its address. Each reservation is tagged with a 32-bit key drawn from a free-running allocation counter. A store-conditional command carries an address, a data word and the key the client was given. It writes memory only if a live reservation with exactly that address and key is still in the table.

Clients do not need an identity. Any client asking to reserve an address that is already reserved receives the key already on record for that address. A reservation that has been consumed is never matched again, because its key is never handed out twice: the key counter only moves forward. When all slots are occupied, a rotating victim pointer chooses which reservation to drop. A store-conditional aimed at a dropped reservation fails.

Requests and responses each use a valid/ready handshake. Only one command is in flight at a time.

Top module: `resv_table_top`

## Requirements
- R1: After reset, no reservation is live, the key counter is 0, reqReady is high and rspValid is low; the first load-linked after reset therefore returns key 0.
- R2: A load-linked (reqCmd 1) to an address with no live reservation returns the memory word at that address and the current key counter value as the key. It records that address and key in a table slot, and the key counter advances by one.
- R3: A load-linked to an address that already has a live reservation returns the memory word and the key already recorded for that address. It allocates no slot and leaves the key counter unchanged.
- R4: A store-conditional (reqCmd 2) whose address and key both match a live reservation writes reqData to memory at that address, removes that reservation and returns rspStatus 0.
- R5: A store-conditional with no live reservation matching both its address and its key returns rspStatus 1. It leaves memory and all reservations unchanged.
- R6: A plain read (reqCmd 0) returns the memory word with rspKey 0 and rspStatus 0, and creates or removes no reservation.
- R7: A new reservation takes the lowest-numbered free slot. When all ENTRIES slots are live, it replaces the slot at a victim pointer. The pointer is 0 after reset and advances by one, wrapping, on each replacement.
- R8: A request is taken on a cycle with reqValid and reqReady both high. reqReady stays low until the response has been taken. While rspValid is high and rspReady is low, rspValid, rspData, rspKey and rspStatus hold steady.
- R9: reqCmd 3 behaves as a plain read. For a store-conditional, the response carries rspData 0 and echoes the request key on rspKey.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can take a request |
| reqCmd | input | 2 | 0 read, 1 load-linked, 2 store-conditional, 3 read |
| reqAddr | input | ADDR_W (8) | Word address |
| reqData | input | DATA_W (32) | Store-conditional data |
| reqKey | input | KEY_W (32) | Store-conditional key |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Client takes the response |
| rspData | output | DATA_W (32) | Memory word (0 for store-conditional) |
| rspKey | output | KEY_W (32) | Reservation key or echoed key |
| rspStatus | output | 1 | 0 success, 1 failure |

## Verification
The embedded assertions check several properties on every cycle. At most one live slot ever matches an address. The key counter moves only when a fresh reservation is allocated. A successful store-conditional removes exactly one reservation, and a failed one leaves the valid set untouched. A replacement leaves the table full. The response also holds steady under backpressure. Other behaviours only show up across a sequence of commands, so the bench's scenarios must demonstrate them. These include the memory value seen after a failed store-conditional, the key handed out to a repeated load-linked, lowest-free-slot placement, and the order in which the rotating victim pointer drops reservations.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic [1:0] {
    CMD_READ = 2'd0,
    CMD_LL   = 2'd1,
    CMD_SC   = 2'd2,
    CMD_ALT  = 2'd3
  } cmdE;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch the incoming request
    logic exec;     // perform lookup, update table/memory, register response
  } ctrlStrobeT;

  localparam logic STATUS_OK   = 1'b0;
  localparam logic STATUS_FAIL = 1'b1;

endpackage

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       rspValid,
  input  logic       rspReady,
  output ctrlStrobeT strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_RESP} stateE;
  stateE state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid) stateNext = ST_EXEC;
      ST_EXEC: stateNext = ST_RESP;
      ST_RESP: if (rspReady) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady       = (state == ST_IDLE);
  assign rspValid       = (state == ST_RESP);
  assign strobe.capture = (state == ST_IDLE) && reqValid;
  assign strobe.exec    = (state == ST_EXEC);

  // R8: a response not yet taken stays offered
  a_r8_rsp_held: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid);

  // R8: a taken request is followed by its execution step
  a_r8_capture_exec: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> strobe.exec && !reqReady);

endmodule

// File: rtl/resv_datapath.sv
module resv_datapath
  import resv_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int KEY_W   = 32,
  parameter int ENTRIES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [1:0]        reqCmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [KEY_W-1:0]  reqKey,
  output logic [DATA_W-1:0] rspData,
  output logic [KEY_W-1:0]  rspKey,
  output logic              rspStatus
);

  localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int MEM_DEPTH = 1 << ADDR_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  // Latched request
  logic [1:0]        cmdQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [KEY_W-1:0]  keyQ;

  // Reservation table and word store
  logic [ENTRIES-1:0] tblValid;
  logic [ADDR_W-1:0]  tblAddr [ENTRIES];
  logic [KEY_W-1:0]   tblKey  [ENTRIES];
  logic [DATA_W-1:0]  mem     [MEM_DEPTH];

  logic [KEY_W-1:0]   keyCtr;
  logic [IDX_W-1:0]   victimPtr;

  // Associative compare
  logic [ENTRIES-1:0] addrHit, keyHit;
  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    assign addrHit[g] = tblValid[g] && (tblAddr[g] == addrQ);
    assign keyHit[g]  = addrHit[g] && (tblKey[g] == keyQ);
  end

  // Hit index and lowest free slot
  logic [IDX_W-1:0] hitIdx, freeIdx;
  logic             anyFree;
  always_comb begin
    hitIdx  = '0;
    freeIdx = '0;
    anyFree = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (addrHit[i]) hitIdx = IDX_W'(i);
      if (!tblValid[i]) begin
        anyFree = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
  end

  logic isLL, isSC, llHit, scWin, allocNew;
  logic [IDX_W-1:0] allocIdx;
  logic [KEY_W-1:0] hitKey;

  assign isLL     = (cmdQ == CMD_LL);
  assign isSC     = (cmdQ == CMD_SC);
  assign llHit    = |addrHit;
  assign scWin    = strobe.exec && isSC && (|keyHit);
  assign allocNew = strobe.exec && isLL && !llHit;
  assign allocIdx = anyFree ? freeIdx : victimPtr;
  assign hitKey   = tblKey[hitIdx];

  // Request capture
  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      cmdQ  <= reqCmd;
      addrQ <= reqAddr;
      dataQ <= reqData;
      keyQ  <= reqKey;
    end
  end

  // Table contents (no reset needed: guarded by valid bits)
  always_ff @(posedge clk) begin
    if (allocNew) begin
      tblAddr[allocIdx] <= addrQ;
      tblKey[allocIdx]  <= keyCtr;
    end
  end

  // Word store
  always_ff @(posedge clk) begin
    if (scWin) mem[addrQ] <= dataQ;
  end

  // Valid bits, key counter, victim pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tblValid  <= '0;
      keyCtr    <= '0;
      victimPtr <= '0;
    end else begin
      if (allocNew) begin
        tblValid[allocIdx] <= 1'b1;
        keyCtr             <= keyCtr + 1'b1;
        if (!anyFree)
          victimPtr <= (victimPtr == LAST_IDX) ? '0 : victimPtr + 1'b1;
      end else if (scWin) begin
        tblValid[hitIdx] <= 1'b0;
      end
    end
  end

  // Response registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspData   <= '0;
      rspKey    <= '0;
      rspStatus <= STATUS_OK;
    end else if (strobe.exec) begin
      unique case (cmdQ)
        CMD_LL: begin
          rspData   <= mem[addrQ];
          rspKey    <= llHit ? hitKey : keyCtr;
          rspStatus <= STATUS_OK;
        end
        CMD_SC: begin
          rspData   <= '0;
          rspKey    <= keyQ;
          rspStatus <= (|keyHit) ? STATUS_OK : STATUS_FAIL;
        end
        default: begin
          rspData   <= mem[addrQ];
          rspKey    <= '0;
          rspStatus <= STATUS_OK;
        end
      endcase
    end
  end

  // R3: no two live slots ever reserve the same address
  a_r3_single_slot: assert property (@(posedge clk) disable iff (!rstN)
    strobe.exec |-> $onehot0(addrHit));

  // R3: the key counter only moves on a fresh allocation
  a_r3_ctr_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !allocNew |=> $stable(keyCtr));

  // R4: a winning store-conditional frees exactly one slot
  a_r4_frees_one: assert property (@(posedge clk) disable iff (!rstN)
    scWin |=> $countones(tblValid) == $past($countones(tblValid)) - 1);

  // R5: a losing store-conditional leaves every slot as it was
  a_r5_table_kept: assert property (@(posedge clk) disable iff (!rstN)
    strobe.exec && isSC && !(|keyHit) |=> $stable(tblValid));

  // R7: a replacement keeps the table full
  a_r7_evict_full: assert property (@(posedge clk) disable iff (!rstN)
    allocNew && !anyFree |=> $countones(tblValid) == ENTRIES);

endmodule

// File: rtl/resv_table_top.sv
module resv_table_top
  import resv_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int KEY_W   = 32,
  parameter int ENTRIES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqCmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [KEY_W-1:0]  reqKey,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [DATA_W-1:0] rspData,
  output logic [KEY_W-1:0]  rspKey,
  output logic              rspStatus
);

  ctrlStrobeT strobe;

  resv_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .rspReady (rspReady),
    .strobe   (strobe)
  );

  resv_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .KEY_W   (KEY_W),
    .ENTRIES (ENTRIES)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqCmd    (reqCmd),
    .reqAddr   (reqAddr),
    .reqData   (reqData),
    .reqKey    (reqKey),
    .rspData   (rspData),
    .rspKey    (rspKey),
    .rspStatus (rspStatus)
  );

  // R8: response payload is frozen while it waits
  a_r8_payload_stable: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> $stable(rspData) && $stable(rspKey) && $stable(rspStatus));

  // R8: never accepting and responding at once
  a_r8_one_in_flight: assert property (@(posedge clk) disable iff (!rstN)
    !(reqReady && rspValid));

endmodule

// File: tb/resv_table_top_test.sv
module resv_table_top_test;

  localparam int NE = 32;
  localparam int NA = 48;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqCmd = 2'd0;
  logic [7:0]  reqAddr = '0;
  logic [31:0] reqData = '0;
  logic [31:0] reqKey = '0;
  logic        rspValid;
  logic        rspReady = 1'b1;
  logic [31:0] rspData;
  logic [31:0] rspKey;
  logic        rspStatus;

  int testsRun = 0;
  int testsFailed = 0;

  // Requirement-level reference state
  logic        mValid [NE];
  logic [7:0]  mAddr  [NE];
  logic [31:0] mKey   [NE];
  logic [31:0] mMem   [256];
  logic        mKnown [256];
  logic [31:0] mCtr;
  int          mVic;

  always #4 clk = ~clk;

  resv_table_top uut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .reqCmd(reqCmd), .reqAddr(reqAddr), .reqData(reqData), .reqKey(reqKey),
    .rspValid(rspValid), .rspReady(rspReady),
    .rspData(rspData), .rspKey(rspKey), .rspStatus(rspStatus)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int findAddr(input logic [7:0] a);
    for (int i = 0; i < NE; i++) if (mValid[i] && mAddr[i] == a) return i;
    return -1;
  endfunction

  // Issue one command, check its response against the reference state
  task automatic doReq(input logic [1:0] cmd, input logic [7:0] a,
                       input logic [31:0] d, input logic [31:0] k, input int hold);
    logic [31:0] eData, eKey;
    logic eStat, dataKnown;
    string tag;
    int j, slot;
    dataKnown = 1'b1;
    eData = '0; eKey = '0; eStat = 1'b0;
    if (cmd == 2'd1) begin
      eData = mMem[a]; dataKnown = mKnown[a];
      j = findAddr(a);
      if (j >= 0) begin
        eKey = mKey[j]; tag = "R3";
      end else begin
        slot = -1;
        for (int i = NE - 1; i >= 0; i--) if (!mValid[i]) slot = i;
        if (slot < 0) begin
          slot = mVic; mVic = (mVic + 1) % NE; tag = "R7";
        end else tag = "R2";
        mValid[slot] = 1'b1; mAddr[slot] = a; mKey[slot] = mCtr;
        eKey = mCtr; mCtr = mCtr + 1;
      end
    end else if (cmd == 2'd2) begin
      j = findAddr(a);
      eKey = k;
      if (j >= 0 && mKey[j] == k) begin
        eStat = 1'b0; mValid[j] = 1'b0; mMem[a] = d; mKnown[a] = 1'b1; tag = "R4";
      end else begin
        eStat = 1'b1; tag = "R5";
      end
    end else begin
      eData = mMem[a]; dataKnown = mKnown[a];
      tag = (cmd == 2'd3) ? "R9" : "R6";
    end

    @(negedge clk);
    check(reqReady === 1'b1, "R8 ready before request", 32'(reqReady), 1);
    reqValid = 1'b1; reqCmd = cmd; reqAddr = a; reqData = d; reqKey = k;
    rspReady = (hold == 0);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    while (rspValid !== 1'b1) begin
      check(reqReady === 1'b0, "R8 busy while executing", 32'(reqReady), 0);
      @(negedge clk);
    end
    if (hold > 0) begin
      logic [31:0] hData, hKey;
      logic hStat;
      hData = rspData; hKey = rspKey; hStat = rspStatus;
      for (int c = 0; c < hold; c++) begin
        @(negedge clk);
        check(rspValid === 1'b1 && reqReady === 1'b0, "R8 response held", 32'(rspValid), 1);
        check(rspData === hData && rspKey === hKey && rspStatus === hStat,
              "R8 payload stable", rspKey, hKey);
      end
      rspReady = 1'b1;
    end
    if (dataKnown) check(rspData === eData, {tag, " data"}, rspData, eData);
    check(rspKey === eKey, {tag, " key"}, rspKey, eKey);
    check(rspStatus === eStat, {tag, " status"}, 32'(rspStatus), 32'(eStat));
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsFailed++;
    testsRun++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    for (int i = 0; i < NE; i++) begin mValid[i] = 1'b0; mAddr[i] = '0; mKey[i] = '0; end
    for (int i = 0; i < 256; i++) begin mMem[i] = '0; mKnown[i] = 1'b0; end
    mCtr = '0; mVic = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: idle state after reset
    check(reqReady === 1'b1, "R1 reqReady after reset", 32'(reqReady), 1);
    check(rspValid === 1'b0, "R1 rspValid after reset", 32'(rspValid), 0);

    // R1: first key is 0; seed memory with LL+SC on every used address
    for (int a = 0; a < NA; a++) begin
      doReq(2'd1, 8'(a), '0, '0, 0);
      doReq(2'd2, 8'(a), 32'(a * 7 + 3), 32'(a), 0);
    end

    // R3 repeat LL, R5 wrong key, R6 read, R4 correct key, R5 reuse
    doReq(2'd1, 8'd5, '0, '0, 0);
    doReq(2'd1, 8'd5, '0, '0, 0);
    doReq(2'd2, 8'd5, 32'hDEAD0005, mCtr, 0);
    doReq(2'd0, 8'd5, '0, '0, 0);
    doReq(2'd2, 8'd5, 32'hBEEF0005, mCtr - 1, 0);
    doReq(2'd2, 8'd5, 32'hCAFE0005, mCtr - 1, 0);
    doReq(2'd0, 8'd5, '0, '0, 0);
    // R5: no reservation at all
    doReq(2'd2, 8'd9, 32'h12345678, 32'd0, 0);
    doReq(2'd3, 8'd9, '0, '0, 0);

    // R7: fill, then replace in rotating order, then reuse a freed slot
    for (int a = 0; a < NE; a++) doReq(2'd1, 8'(a), '0, '0, 0);
    for (int a = NE; a < NE + 4; a++) doReq(2'd1, 8'(a), '0, '0, 0);
    doReq(2'd2, 8'd0, 32'h0A0A0A0A, mCtr - 36, 0);
    doReq(2'd2, 8'd4, 32'h04040404, mCtr - 32, 0);
    doReq(2'd1, 8'd40, '0, '0, 0);
    doReq(2'd1, 8'd41, '0, '0, 0);

    // R8: backpressure on the response
    doReq(2'd1, 8'd7, '0, '0, 3);
    doReq(2'd0, 8'd7, '0, '0, 2);

    // Mixed sweep over all command codes
    lfsr = 32'h1ACE5EED;
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      logic [31:0] k;
      int j;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = 8'(lfsr[15:8] % NA);
      j = findAddr(a);
      k = (j >= 0 && lfsr[4]) ? mKey[j] : (lfsr[5] ? mCtr - 1 : lfsr);
      doReq(lfsr[1:0], a, lfsr ^ 32'h5A5A0000, k, (n % 17 == 0) ? 1 : 0);
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule